// File: doc/BRIEF.md
# Monochrome-to-Color Expansion Unit

This unit turns a packed one-bit-per-pixel bitmap, supplied by a host processor one 32-bit word at a time, into a stream of destination pixel bytes. Each bitmap bit picks one of two programmable colors. A set bit picks the foreground color and a clear bit picks the background color. The unit emits one byte per clock. Pixels may be 1, 2, 3 or 4 bytes wide, and a wide pixel comes out least significant byte first, one byte lane per cycle.

The host offers a word with a valid/ready handshake. With byte granularity only the low 8 bits of the word carry pixels, consumed from bit 7 downwards. With dword granularity all 32 bits carry pixels, consumed from bit 31 downwards. Every output byte is paired with the bitmap bit that produced it, so that a later transparency stage can drop background bytes. Memory writes, raster operations and address generation belong to the neighbouring stages.

Top module: `mono_color_expander`

## Requirements
- R1: `depth_i` codes 0, 1, 2 and 3 select 1, 2, 3 and 4 bytes per pixel. An accepted word yields exactly (pixels per word × bytes per pixel) valid bytes, back to back.
- R2: With `dword_i`=0 a word holds 8 pixels, taken from bit 7 down to bit 0, and bits 31..8 are ignored. With `dword_i`=1 a word holds 32 pixels, taken from bit 31 down to bit 0.
- R3: The byte for lane L equals bits [8L+7:8L] of `fg_color_i` when the pixel bit is 1, and of `bg_color_i` when it is 0.
- R4: Within a pixel, lanes are emitted in the order 0 to bytes-per-pixel−1. The next bitmap bit is used only after the last lane of the current pixel.
- R5: The internal byte counter wraps at 8 × bytes-per-pixel. Every word therefore starts on lane 0, and consecutive words expand identically.
- R6: `word_ready_o` is high exactly when the unit is idle. A word is taken on a clock edge with `word_valid_i` and `word_ready_o` both high. Its first byte is valid in the next cycle. Ready returns in the cycle after the last byte.
- R7: A word offered while the unit is busy is not taken and does not disturb the bytes in progress.
- R8: After reset `word_ready_o` is 1 and `byte_valid_o` is 0.
- R9: `mask_o` carries the bitmap bit of the pixel that the current byte belongs to.
- R10: `depth_i` and `dword_i` are sampled when a word is accepted. Changing them during a word has no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Host word offered |
| word_data_i | input | 32 | Host bitmap word |
| word_ready_o | output | 1 | Unit can accept a word |
| depth_i | input | 2 | Bytes per pixel minus one |
| dword_i | input | 1 | 1: 32 pixels per word, 0: 8 pixels per word |
| fg_color_i | input | 32 | Color for set bits |
| bg_color_i | input | 32 | Color for clear bits |
| byte_o | output | 8 | Expanded pixel byte |
| mask_o | output | 1 | Bitmap bit of the current byte |
| byte_valid_o | output | 1 | `byte_o` and `mask_o` are valid |

## Verification
A word accepted at edge k shows its first byte in the cycle after edge k. Byte n of that word is due n cycles later, and ready returns one cycle after the final byte. The bench drives inputs on falling edges and compares each byte, mask bit and valid flag at the falling edge that follows the edge which produced it. Its expected byte sequence is computed from the pixel index and lane. The sweep covers every depth and both granularities with several bit patterns. It also repeats the sweep while a competing word is offered and the configuration is flipped in mid-word.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int unsigned MAX_BPP = 4;
  localparam int unsigned LANE_W  = $clog2(MAX_BPP);

  typedef enum logic [LANE_W-1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_16 = 2'd1,
    DEPTH_24 = 2'd2,
    DEPTH_32 = 2'd3
  } depth_e;

  typedef struct packed {
    depth_e depth;
    logic   dword;
  } cfg_t;
endpackage

// File: rtl/mce_lane_ctr.sv
module mce_lane_ctr
  import mce_pkg::*;
#(
  parameter int unsigned XCNT_W = LANE_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  depth_e            depth_i,
  output logic [LANE_W-1:0] lane_o,
  output logic              last_o,
  output logic [XCNT_W-1:0] xcnt_o
);
  logic [XCNT_W-1:0] xcnt_q, wrap_at;

  // 8 * bytes_per_pixel - 1
  assign wrap_at = {depth_i, 3'b111};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              xcnt_q <= '0;
    else if (step_i) begin
      if (xcnt_q == wrap_at)  xcnt_q <= '0;
      else                    xcnt_q <= xcnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (depth_i)
      DEPTH_8:  lane_o = '0;
      DEPTH_16: lane_o = {1'b0, xcnt_q[0]};
      DEPTH_24: lane_o = LANE_W'(xcnt_q % XCNT_W'(3));
      default:  lane_o = xcnt_q[LANE_W-1:0];
    endcase
  end

  assign last_o = (lane_o == depth_i);
  assign xcnt_o = xcnt_q;

  a_r5_xcnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xcnt_q <= wrap_at);
  a_r4_lane_in_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_o <= depth_i);
endmodule

// File: rtl/mce_bit_shifter.sv
module mce_bit_shifter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BCNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dword_i,
  input  logic              shift_i,
  output logic              mask_o,
  output logic              busy_o,
  output logic [BCNT_W-1:0] bits_left_o
);
  logic [DATA_W-1:0] sreg_q;
  logic [BCNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      sreg_q <= data_i;
      cnt_q  <= dword_i ? BCNT_W'(DATA_W) : BCNT_W'(8);
    end else if (shift_i) begin
      sreg_q <= sreg_q << 1;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // live pixel bit sits at the top of the selected granule
  assign mask_o      = dword_i ? sreg_q[DATA_W-1] : sreg_q[7];
  assign busy_o      = (cnt_q != '0);
  assign bits_left_o = cnt_q;

  a_r2_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> busy_o);
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BCNT_W'(DATA_W));
endmodule

// File: rtl/mce_color_sel.sv
module mce_color_sel
  import mce_pkg::*;
#(
  parameter int unsigned COLOR_W = 8 * MAX_BPP
) (
  input  logic               mask_i,
  input  logic [LANE_W-1:0]  lane_i,
  input  logic [COLOR_W-1:0] fg_i,
  input  logic [COLOR_W-1:0] bg_i,
  output logic [7:0]         byte_o
);
  localparam int unsigned NLANE = COLOR_W / 8;

  logic [COLOR_W-1:0] color;
  logic [7:0]         lanes [NLANE];

  assign color = mask_i ? fg_i : bg_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = color[8*g +: 8];
  end

  assign byte_o = lanes[lane_i];
endmodule

// File: rtl/mono_color_expander.sv
module mono_color_expander
  import mce_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COLOR_W = 8 * MAX_BPP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [DATA_W-1:0]  word_data_i,
  output logic               word_ready_o,
  input  logic [LANE_W-1:0]  depth_i,
  input  logic               dword_i,
  input  logic [COLOR_W-1:0] fg_color_i,
  input  logic [COLOR_W-1:0] bg_color_i,
  output logic [7:0]         byte_o,
  output logic               mask_o,
  output logic               byte_valid_o
);
  localparam int unsigned BCNT_W = $clog2(DATA_W + 1);
  localparam int unsigned XCNT_W = LANE_W + 3;

  cfg_t              cfg_q;
  logic              accept, busy, last, mask;
  logic [LANE_W-1:0] lane;
  logic [XCNT_W-1:0] xcnt;
  logic [BCNT_W-1:0] bits_left;

  assign accept = word_valid_i & word_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '{depth: DEPTH_8, dword: 1'b0};
    else if (accept) cfg_q <= '{depth: depth_e'(depth_i), dword: dword_i};
  end

  mce_bit_shifter #(.DATA_W(DATA_W), .BCNT_W(BCNT_W)) i_shift (
    .clk_i, .rst_ni,
    .load_i      (accept),
    .data_i      (word_data_i),
    .dword_i     (accept ? dword_i : cfg_q.dword),
    .shift_i     (busy & last),
    .mask_o      (mask),
    .busy_o      (busy),
    .bits_left_o (bits_left)
  );

  mce_lane_ctr #(.XCNT_W(XCNT_W)) i_lane (
    .clk_i, .rst_ni,
    .step_i  (busy),
    .depth_i (cfg_q.depth),
    .lane_o  (lane),
    .last_o  (last),
    .xcnt_o  (xcnt)
  );

  mce_color_sel #(.COLOR_W(COLOR_W)) i_sel (
    .mask_i (mask),
    .lane_i (lane),
    .fg_i   (fg_color_i),
    .bg_i   (bg_color_i),
    .byte_o (byte_o)
  );

  assign word_ready_o = ~busy;
  assign byte_valid_o = busy;
  assign mask_o       = mask;

  a_r6_accept_then_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> byte_valid_o);
  a_r5_word_starts_lane0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (xcnt == '0));
  a_r4_bit_held_in_pixel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !last) |=> ($stable(mask_o) && $stable(bits_left)));
  a_r4_bit_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && last) |=> (bits_left == $past(bits_left) - 1'b1));
  a_r10_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> $stable(cfg_q));
  a_r6_ready_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(byte_valid_o) |-> word_ready_o);
endmodule

// File: tb/test_mono_color_expander.sv
`timescale 1ns/1ps
module test_mono_color_expander;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_data_i = '0;
  logic        word_ready_o;
  logic [1:0]  depth_i = '0;
  logic        dword_i = 1'b0;
  logic [31:0] fg_color_i = 32'hF4F3_F2F1;
  logic [31:0] bg_color_i = 32'hB4B3_B2B1;
  logic [7:0]  byte_o;
  logic        mask_o;
  logic        byte_valid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  mono_color_expander i_mono_color_expander (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge with the unit idle
  task automatic run_word(input logic [1:0] dep, input logic gran, input logic [31:0] data,
                          input bit noise);
    int npix = gran ? 32 : 8;
    int bpp  = int'(dep) + 1;
    int total = npix * bpp;
    int n = 0;
    depth_i = dep; dword_i = gran; word_data_i = data; word_valid_i = 1'b1;
    @(negedge clk_i);
    word_valid_i = noise;
    word_data_i  = ~data;
    if (noise) begin depth_i = ~dep; dword_i = ~gran; end
    for (int p = 0; p < npix; p++) begin
      for (int l = 0; l < bpp; l++) begin
        logic bitv = gran ? data[31-p] : data[7-p];
        logic [31:0] col = bitv ? fg_color_i : bg_color_i;
        // R1 R2 R3 R4 R5 R7 R9 R10: {valid, mask, byte}
        chk(noise ? "R7/R10 byte" : "R1-3,R4,R5,R9 byte",
            {22'd0, byte_valid_o, mask_o, byte_o}, {22'd0, 1'b1, bitv, col[8*l +: 8]});
        n++;
        if (n == total) word_valid_i = 1'b0;
        @(negedge clk_i);
      end
    end
    // R6: ready back one cycle after the last byte
    chk("R6 idle after word", {30'd0, word_ready_o, byte_valid_o}, {30'd0, 2'b10});
  endtask

  initial begin
    logic [31:0] pats [4] = '{32'hA5C3_0F81, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5ACE};
    repeat (2) @(negedge clk_i);
    // R8 reset state
    chk("R8 ready in reset", {31'd0, word_ready_o}, 32'd1);
    chk("R8 no valid in reset", {31'd0, byte_valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 idle after reset", {30'd0, word_ready_o, byte_valid_o}, {30'd0, 2'b10});
    for (int d = 0; d < 4; d++)
      for (int g = 0; g < 2; g++)
        for (int k = 0; k < 4; k++)
          run_word(2'(d), 1'(g), pats[k], 1'b0);
    fg_color_i = 32'h1122_3344; bg_color_i = 32'h99AA_BBCC;
    for (int d = 0; d < 4; d++)
      for (int g = 0; g < 2; g++)
        run_word(2'(d), 1'(g), pats[(d + g) % 4] ^ 32'h5A5A_5A5A, 1'b1);
    // R6: idle gap, then no spurious bytes
    repeat (3) @(negedge clk_i);
    chk("R6 stays idle", {31'd0, byte_valid_o}, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule